// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This unit owns a small byte-addressed, word-organised memory. A single requester uses it for two indivisible operations. The first is a byte test-and-set. The second is a 32-bit compare-and-swap. Each accepted request is served by one fixed sequence: read, decide, write back. The requester cannot present another access until that sequence has finished, so nothing can land between the read and the write.

Test-and-set reports the top bit of the byte as it was before the operation, and fills the byte with ones. Compare-and-swap compares the addressed word with a comparand. On a match it stores the new value. On a mismatch it hands the current word back so the caller can refresh its comparand. Both operations return the old contents. A compare-and-swap whose address is not word-aligned is refused with an error flag. Memory contents are not defined after reset. A caller reads a word without changing it by issuing a compare-and-swap whose comparand and new value are equal.

Top module: `atomic_rmw_unit`

## Requirements
- R1: After reset `req_ready` is high, and `rsp_done` and `rsp_err` are low.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low for the next two cycles. Memory is written only while `req_ready` is low.
- R3: The response is a `rsp_done` pulse lasting exactly one cycle. It is seen in the third cycle after the accepting edge, and `req_ready` is high again in that same cycle.
- R4: Test-and-set (`req_op`=0) selects byte lane `req_addr[1:0]`, where lane i is bits 8i+7..8i of the word at `req_addr[ADDR_W-1:2]`. It returns `rsp_cc` = {0, bit 7 of that byte before the operation}.
- R5: Test-and-set writes 8'hFF into the selected lane and leaves the other three lanes of the word unchanged. It never raises `rsp_err`.
- R6: For test-and-set, `rsp_old` holds the old byte in its own lane and zero in every other bit.
- R7: Compare-and-swap (`req_op`=1) with an aligned address and a memory word equal to `req_cmp` stores `req_new`. It returns `rsp_cc`=0 and the old word in `rsp_old`.
- R8: Compare-and-swap with an aligned address and a memory word different from `req_cmp` leaves memory unchanged. It returns `rsp_cc`=1 and the current word in `rsp_old`.
- R9: Compare-and-swap with `req_addr[1:0]` not zero raises `rsp_err`, returns `rsp_cc`=3 and `rsp_old`=0, and leaves memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_op | input | 1 | 0 = byte test-and-set, 1 = word compare-and-swap |
| req_addr | input | ADDR_W | Byte address |
| req_cmp | input | 32 | Comparand for compare-and-swap |
| req_new | input | 32 | Replacement word for compare-and-swap |
| rsp_done | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Misaligned compare-and-swap refused |
| rsp_cc | output | 2 | Condition code |
| rsp_old | output | 32 | Old contents (byte in its lane for test-and-set) |

## Verification
The bench drives test-and-set into every byte lane. It uses bytes whose top bit is set, bytes whose top bit is clear, and bytes that already hold all ones. A design that picked the wrong lane, took the code from the new value, or clobbered the neighbouring bytes would return wrong old values on later accesses to the same word.

Compare-and-swap is exercised on forced matches, on mismatches, and at every misaligned offset. Each refused or mismatching request is followed by a read-back, so a stray write is exposed. Every request also checks the busy window and the position of the one-cycle response strobe, which catches an extra or a missing pipeline stage.

// File: rtl/atomic_rmw_pkg.sv
// Package: shared opcodes, sequencer states and condition codes for the
// atomic read-modify-write unit. Assumes a fixed 32-bit word.
package atomic_rmw_pkg;
    localparam int WORD_W = 32;
    localparam int LANES  = WORD_W / 8;

    typedef enum logic {
        OP_TAS = 1'b0,
        OP_CAS = 1'b1
    } rmw_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } rmw_state_e;

    localparam logic [1:0] CC_ZERO = 2'd0;
    localparam logic [1:0] CC_ONE  = 2'd1;
    localparam logic [1:0] CC_ERR  = 2'd3;
endpackage

// File: rtl/rmw_ctrl.sv
// Module: sequencer. It takes one request when idle, latches it, and steps
// through READ and WRITE before it opens the handshake again.
// Assumes: the requester holds request fields stable while valid is high.
module rmw_ctrl
    import atomic_rmw_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_cmp,
    input  logic [WORD_W-1:0] req_new,
    output logic              req_ready,
    output rmw_state_e        state,
    output rmw_op_e           lat_op,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [WORD_W-1:0] lat_cmp,
    output logic [WORD_W-1:0] lat_new
);
    rmw_state_e state_nx;

    assign req_ready = (state == ST_IDLE);

    // Next-state choice: a fixed three-step walk, started by the handshake.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req_valid) state_nx = ST_READ;
            ST_READ:  state_nx = ST_WRITE;
            ST_WRITE: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Capture the request fields on the accepting edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_op   <= OP_TAS;
            lat_addr <= '0;
            lat_cmp  <= '0;
            lat_new  <= '0;
        end else if (req_ready && req_valid) begin
            lat_op   <= rmw_op_e'(req_op);
            lat_addr <= req_addr;
            lat_cmp  <= req_cmp;
            lat_new  <= req_new;
        end
    end
endmodule

// File: rtl/rmw_store.sv
// Module: word storage with one registered read port and one write port.
// Assumes: contents are left undefined at reset; the sequencer never reads
// and writes in the same cycle.
module rmw_store
    import atomic_rmw_pkg::*;
#(
    parameter int WORDS = 64,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data
);
    logic [WORD_W-1:0] cells [WORDS];

    // Registered read of the addressed word.
    always_ff @(posedge clk) begin
        if (rd_en) rd_data <= cells[rd_idx];
    end

    // Write-back of the decided word.
    always_ff @(posedge clk) begin
        if (wr_en) cells[wr_idx] <= wr_data;
    end
endmodule

// File: rtl/rmw_decide.sv
// Module: purely combinational decision. It takes the fetched word and the
// latched request and gives the write enable, write data and response fields.
// Assumes: cur_word is the word read for this request.
module rmw_decide
    import atomic_rmw_pkg::*;
(
    input  rmw_op_e           op,
    input  logic [1:0]        lane,
    input  logic [WORD_W-1:0] cur_word,
    input  logic [WORD_W-1:0] cmp_word,
    input  logic [WORD_W-1:0] new_word,
    output logic              we,
    output logic [WORD_W-1:0] wdata,
    output logic              err,
    output logic [1:0]        cc,
    output logic [WORD_W-1:0] old
);
    logic [7:0] old_byte;
    logic [4:0] bit_base;

    assign bit_base = {lane, 3'b000};
    assign old_byte = cur_word[bit_base +: 8];

    // Pick the outcome for the operation in hand.
    always_comb begin
        we    = 1'b0;
        wdata = cur_word;
        err   = 1'b0;
        cc    = CC_ZERO;
        old   = '0;
        if (op == OP_TAS) begin
            we                  = 1'b1;
            wdata[bit_base +: 8] = 8'hFF;
            cc                  = {1'b0, old_byte[7]};
            old[bit_base +: 8]  = old_byte;
        end else if (lane != 2'd0) begin
            err = 1'b1;
            cc  = CC_ERR;
        end else if (cur_word == cmp_word) begin
            we    = 1'b1;
            wdata = new_word;
            cc    = CC_ZERO;
            old   = cur_word;
        end else begin
            cc  = CC_ONE;
            old = cur_word;
        end
    end
endmodule

// File: rtl/atomic_rmw_unit.sv
// Module: top of the atomic read-modify-write unit. It ties the sequencer,
// the storage and the decision logic together and registers the response.
// Assumes: a single requester; byte address, four lanes per word.
module atomic_rmw_unit
    import atomic_rmw_pkg::*;
#(
    parameter int ADDR_W = 8,
    localparam int IDX_W = ADDR_W - 2,
    localparam int WORDS = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_cmp,
    input  logic [31:0]       req_new,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [1:0]        rsp_cc,
    output logic [31:0]       rsp_old
);
    rmw_state_e        state;
    rmw_op_e           lat_op;
    logic [ADDR_W-1:0] lat_addr;
    logic [WORD_W-1:0] lat_cmp, lat_new, cur_word;
    logic [WORD_W-1:0] dec_wdata, dec_old;
    logic              dec_we, dec_err, store_we;
    logic [1:0]        dec_cc;

    rmw_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_cmp(req_cmp), .req_new(req_new),
        .req_ready(req_ready), .state(state), .lat_op(lat_op),
        .lat_addr(lat_addr), .lat_cmp(lat_cmp), .lat_new(lat_new)
    );

    assign store_we = (state == ST_WRITE) && dec_we;

    rmw_store #(.WORDS(WORDS)) store_i (
        .clk(clk), .rd_en(state == ST_READ), .rd_idx(lat_addr[ADDR_W-1:2]),
        .rd_data(cur_word), .wr_en(store_we), .wr_idx(lat_addr[ADDR_W-1:2]),
        .wr_data(dec_wdata)
    );

    rmw_decide decide_i (
        .op(lat_op), .lane(lat_addr[1:0]), .cur_word(cur_word),
        .cmp_word(lat_cmp), .new_word(lat_new), .we(dec_we),
        .wdata(dec_wdata), .err(dec_err), .cc(dec_cc), .old(dec_old)
    );

    // Response register: one-cycle strobe; the fields hold until the next response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_done <= 1'b0;
            rsp_err  <= 1'b0;
            rsp_cc   <= CC_ZERO;
            rsp_old  <= '0;
        end else begin
            rsp_done <= (state == ST_WRITE);
            if (state == ST_WRITE) begin
                rsp_err <= dec_err;
                rsp_cc  <= dec_cc;
                rsp_old <= dec_old;
            end
        end
    end
endmodule

// File: rtl/atomic_rmw_checker.sv
// Module: protocol and outcome checks for atomic_rmw_unit, attached by bind.
module atomic_rmw_checker #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_op,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_done,
    input logic              rsp_err,
    input logic [1:0]        rsp_cc,
    input logic              store_we
);
    logic accept;
    assign accept = req_valid && req_ready;

    assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);
    assert_write_only_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        store_we |-> !req_ready);
    assert_done_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> ##3 rsp_done);
    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> req_ready);
    assert_misalign_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_op && (req_addr[1:0] != 2'd0)) |-> ##3 (rsp_err && rsp_cc == 2'd3));
    assert_tas_no_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_op) |-> ##3 (!rsp_err && !rsp_cc[1]));
endmodule

bind atomic_rmw_unit atomic_rmw_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .rsp_done(rsp_done),
    .rsp_err(rsp_err), .rsp_cc(rsp_cc), .store_we(store_we)
);

// File: tb/atomic_rmw_unit_tb_top.sv
// Bench: seeded random mix of operations plus directed corners, with a
// word-level reference model kept in the bench.
module atomic_rmw_unit_tb_top;
    localparam int ADDR_W = 8;
    localparam int WORDS  = 1 << (ADDR_W - 2);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_op = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0]       req_cmp = '0, req_new = '0;
    logic              rsp_done, rsp_err;
    logic [1:0]        rsp_cc;
    logic [31:0]       rsp_old;

    int errors = 0;
    int checks = 0;
    logic [31:0] model [WORDS];

    always #2.5 clk = ~clk;

    atomic_rmw_unit #(.ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_cmp(req_cmp),
        .req_new(req_new), .rsp_done(rsp_done), .rsp_err(rsp_err),
        .rsp_cc(rsp_cc), .rsp_old(rsp_old)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] lane_fill(input logic [31:0] w, input logic [1:0] l);
        logic [31:0] r = w;
        r[{l, 3'b000} +: 8] = 8'hFF;
        return r;
    endfunction

    function automatic logic [31:0] lane_only(input logic [31:0] w, input logic [1:0] l);
        logic [31:0] r = '0;
        r[{l, 3'b000} +: 8] = w[{l, 3'b000} +: 8];
        return r;
    endfunction

    // One request: handshake, timing checks, outcome checks, model update.
    task automatic run_op(input logic op, input logic [ADDR_W-1:0] addr,
                          input logic [31:0] cmpv, input logic [31:0] newv);
        logic [31:0] cur, e_old;
        logic [1:0]  e_cc;
        logic        e_err;
        int          idx;
        idx = int'(addr[ADDR_W-1:2]);
        cur = model[idx];
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = addr; req_cmp = cmpv; req_new = newv;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R2", "ready after accept", 64'(req_ready), 64'd0);
        @(negedge clk);
        chk(!req_ready && !rsp_done, "R2", "busy second cycle", {req_ready, rsp_done}, 64'd0);
        @(negedge clk);
        chk(rsp_done && req_ready, "R3", "done and ready", {req_ready, rsp_done}, 64'd3);
        if (!op) begin
            e_err = 1'b0; e_cc = {1'b0, cur[{addr[1:0], 3'b111}]};
            e_old = lane_only(cur, addr[1:0]);
            model[idx] = lane_fill(cur, addr[1:0]);
            chk(rsp_cc == e_cc, "R4", "tas cc", 64'(rsp_cc), 64'(e_cc));
            chk(rsp_old == e_old, "R6", "tas old", 64'(rsp_old), 64'(e_old));
            chk(!rsp_err, "R5", "tas err", 64'(rsp_err), 64'd0);
        end else if (addr[1:0] != 2'd0) begin
            e_err = 1'b1; e_cc = 2'd3; e_old = '0;
            chk(rsp_err == e_err && rsp_cc == e_cc && rsp_old == e_old, "R9", "misaligned",
                {rsp_err, rsp_cc, rsp_old}, {e_err, e_cc, e_old});
        end else if (cur == cmpv) begin
            model[idx] = newv;
            chk(!rsp_err && rsp_cc == 2'd0 && rsp_old == cur, "R7", "cas match",
                {rsp_err, rsp_cc, rsp_old}, {1'b0, 2'd0, cur});
        end else begin
            chk(!rsp_err && rsp_cc == 2'd1 && rsp_old == cur, "R8", "cas mismatch",
                {rsp_err, rsp_cc, rsp_old}, {1'b0, 2'd1, cur});
        end
        @(negedge clk);
        chk(!rsp_done, "R3", "done pulse width", 64'(rsp_done), 64'd0);
    endtask

    // Fill a word through the interface: read its unknown value, then swap.
    task automatic seed_word(input int idx, input logic [31:0] val);
        logic [ADDR_W-1:0] a;
        a = ADDR_W'(idx << 2);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_op = 1'b1; req_addr = a; req_cmp = '0; req_new = '0;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        model[idx] = rsp_old;
        run_op(1'b1, a, rsp_old, val);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rsp_done && !rsp_err, "R1", "reset state",
            {req_ready, rsp_done, rsp_err}, 64'd4);
        for (int i = 0; i < WORDS; i++) seed_word(i, $urandom());
        // Directed test-and-set corners on every lane.
        run_op(1'b1, 8'h10, model[4], 32'h80_7F_00_FF);
        for (int l = 0; l < 4; l++) run_op(1'b0, 8'(8'h10 + l), 32'h0, 32'h0);
        for (int l = 0; l < 4; l++) run_op(1'b0, 8'(8'h10 + l), 32'h0, 32'h0);
        run_op(1'b1, 8'h10, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        // Directed compare-and-swap corners.
        for (int l = 1; l < 4; l++) run_op(1'b1, 8'(8'h20 + l), model[8], 32'h1234_5678);
        run_op(1'b1, 8'h20, model[8], model[8]);
        run_op(1'b1, 8'h20, ~model[8], 32'hDEAD_BEEF);
        run_op(1'b1, 8'h20, model[8], model[8]);
        run_op(1'b1, 8'h20, model[8], 32'h0000_0001);
        run_op(1'b1, 8'h20, model[8], model[8]);
        // Seeded random mix.
        for (int n = 0; n < 400; n++) begin
            logic              op;
            logic [ADDR_W-1:0] a;
            logic [31:0]       c;
            op = 1'($urandom());
            a  = ADDR_W'($urandom());
            if (op && ($urandom() % 4 != 0)) a[1:0] = 2'd0;
            c = ($urandom() % 2 == 0) ? model[int'(a[ADDR_W-1:2])] : $urandom();
            run_op(op, a, c, $urandom());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R3 watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule